// File: doc/BRIEF.md
# Shared-Network Shift and Rotate Unit with Carry Rotates

This block shifts or rotates a data word by any amount from zero to one less than the word width. Six operations are supported: logical shifts left and right, plain rotates left and right, and rotates left and right that pass through a one-bit carry. Each result appears after a single clock edge. A datapath, or a cipher round that needs a word or row rotation, feeds it a word, an amount, an operation code and a carry bit. It gets back the shifted word and a carry-out.

All six operations use one logarithmic right-funnel network. Left-going operations reverse the bit order of the word before the network and again after it. The three operation families differ only in how the funnel's upper half and fill bit are loaded: with zeros, with a second copy of the word, or with the word and the carry as one wider ring. One extra slot in the funnel window returns the carry-out, so no separate carry logic is needed for each operation. A zero amount or an undefined code bypasses the network and returns the data and the carry unchanged.

The outputs are registered. The asynchronous active-low reset is released through a two-stage synchronizer.

Top module: `rotc_shifter`

## Requirements
- R1: While reset is asserted, and for the two clock edges of synchronizer delay after it is released, result_o and carry_o read zero.
- R2: Inputs present before a rising clock edge determine result_o and carry_o right after that edge, with one register stage and no further delay.
- R3: With amt_i equal to 0, every one of the six operations returns data_i unchanged on result_o and carry_i on carry_o.
- R4: Code 000 shifts left and code 001 shifts right by amt_i, filling vacated positions with zeros. carry_o is the last bit pushed out: data_i[32-amt_i] for the left shift and data_i[amt_i-1] for the right shift.
- R5: Code 010 rotates the word left and code 011 rotates it right by amt_i. carry_o is the bit that last crossed the word boundary: result bit 0 for the left rotate and result bit 31 for the right rotate.
- R6: Code 100 rotates the 33-bit value {carry_i, data_i} left and code 101 rotates it right by amt_i. carry_o is the bit that lands in the top (carry) position and result_o holds the lower 32 bits.
- R7: Codes 110 and 111 are undefined. They return data_i on result_o and carry_i on carry_o for any amount.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| data_i | input | 32 | Word to shift or rotate |
| amt_i | input | 5 | Shift or rotate amount, 0 to 31 |
| op_i | input | 3 | Operation code (see R4 to R7) |
| carry_i | input | 1 | Carry-in used by the carry rotates and the bypass |
| result_o | output | 32 | Registered shifted or rotated word |
| carry_o | output | 1 | Registered carry-out |

## Verification
Directed single-bit words at amount 1 and amount 31, with the set bit at either end, separate where the carry bit is taken from in each direction. They also show whether a carry rotate uses a 33-bit ring instead of a 32-bit one. The amount-zero sweep over all six codes with both carry values tells the bypass apart from a network that would still fill or move the carry. The undefined codes are tried with nonzero amounts so that a missing bypass would show. Random words, amounts, codes and carries over thousands of cycles cover every combination of amount bit and operation family against a bit-by-bit stepping model.

// File: rtl/rotc_shifter_pkg.sv
package rotc_shifter_pkg;

  typedef enum logic [2:0] {
    OP_SHL  = 3'b000,
    OP_SHR  = 3'b001,
    OP_ROL  = 3'b010,
    OP_ROR  = 3'b011,
    OP_ROLC = 3'b100,
    OP_RORC = 3'b101
  } shift_op_e;

  // How the upper half of the funnel is loaded
  typedef enum logic [1:0] {
    FILL_ZERO  = 2'd0,
    FILL_WORD  = 2'd1,
    FILL_CARRY = 2'd2
  } fill_kind_e;

  function automatic logic op_is_left(logic [2:0] op);
    return (op == OP_SHL) || (op == OP_ROL) || (op == OP_ROLC);
  endfunction

  function automatic logic op_is_defined(logic [2:0] op);
    return op <= OP_RORC;
  endfunction

  function automatic fill_kind_e fill_of(logic [2:0] op);
    fill_kind_e f;
    case (op)
      OP_ROL, OP_ROR:   f = FILL_WORD;
      OP_ROLC, OP_RORC: f = FILL_CARRY;
      default:          f = FILL_ZERO;
    endcase
    return f;
  endfunction

endpackage

// File: rtl/bs_rst_sync.sv
module bs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/bs_operand_prep.sv
module bs_operand_prep
  import rotc_shifter_pkg::*;
#(
  parameter int W = 32,
  localparam int N = W + 1
) (
  input  logic [W-1:0]   data_i,
  input  logic           carry_i,
  input  logic [2:0]     op_i,
  output logic [2*N-1:0] funnel_o,
  output logic           left_o
);
  logic [W-1:0] rev_w;
  logic [W-1:0] src_w;

  for (genvar i = 0; i < W; i++) begin : g_rev
    assign rev_w[i] = data_i[W-1-i];
  end

  assign left_o = op_is_left(op_i);
  assign src_w  = left_o ? rev_w : data_i;

  // Window bit 0 is the carry slot; bits N-1:1 carry the word.
  always_comb begin
    case (fill_of(op_i))
      FILL_WORD:  funnel_o = {1'b0, src_w, src_w, 1'b0};
      FILL_CARRY: funnel_o = {src_w, carry_i, src_w, carry_i};
      default:    funnel_o = {{N{1'b0}}, src_w, 1'b0};
    endcase
  end
endmodule

// File: rtl/bs_funnel_core.sv
module bs_funnel_core #(
  parameter int W  = 32,
  parameter int AW = 5,
  localparam int N = W + 1
) (
  input  logic [2*N-1:0] funnel_i,
  input  logic [AW-1:0]  amt_i,
  output logic [N-1:0]   win_o
);
  logic [2*N-1:0] stg [AW+1];

  assign stg[0] = funnel_i;

  for (genvar k = 0; k < AW; k++) begin : g_stage
    localparam int SH = 1 << k;
    assign stg[k+1] = amt_i[k] ? (stg[k] >> SH) : stg[k];
  end

  assign win_o = N'(stg[AW]);
endmodule

// File: rtl/bs_result_stage.sv
module bs_result_stage
  import rotc_shifter_pkg::*;
#(
  parameter int W  = 32,
  parameter int AW = 5,
  localparam int N = W + 1
) (
  input  logic [N-1:0]  win_i,
  input  logic          left_i,
  input  logic [W-1:0]  data_i,
  input  logic          carry_i,
  input  logic [AW-1:0] amt_i,
  input  logic [2:0]    op_i,
  output logic [W-1:0]  res_o,
  output logic          carry_o
);
  logic [W-1:0] body_w;
  logic [W-1:0] body_rev_w;
  logic         bypass_w;

  assign body_w = win_i[N-1:1];

  for (genvar i = 0; i < W; i++) begin : g_unrev
    assign body_rev_w[i] = body_w[W-1-i];
  end

  assign bypass_w = (amt_i == '0) || !op_is_defined(op_i);

  always_comb begin
    if (bypass_w) begin
      res_o   = data_i;
      carry_o = carry_i;
    end else begin
      res_o   = left_i ? body_rev_w : body_w;
      carry_o = win_i[0];
    end
  end
endmodule

// File: rtl/rotc_shifter.sv
module rotc_shifter
  import rotc_shifter_pkg::*;
#(
  parameter int W = 32,
  localparam int AW = $clog2(W),
  localparam int N  = W + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  data_i,
  input  logic [AW-1:0] amt_i,
  input  logic [2:0]    op_i,
  input  logic          carry_i,
  output logic [W-1:0]  result_o,
  output logic          carry_o
);
  logic           rst_sync_n;
  logic [2*N-1:0] funnel_w;
  logic           left_w;
  logic [N-1:0]   win_w;
  logic [W-1:0]   res_d;
  logic           carry_d;
  logic [W-1:0]   res_q;
  logic           carry_q;

  bs_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  bs_operand_prep #(.W(W)) prep_i (
    .data_i   (data_i),
    .carry_i  (carry_i),
    .op_i     (op_i),
    .funnel_o (funnel_w),
    .left_o   (left_w)
  );

  bs_funnel_core #(.W(W), .AW(AW)) core_i (
    .funnel_i (funnel_w),
    .amt_i    (amt_i),
    .win_o    (win_w)
  );

  bs_result_stage #(.W(W), .AW(AW)) post_i (
    .win_i   (win_w),
    .left_i  (left_w),
    .data_i  (data_i),
    .carry_i (carry_i),
    .amt_i   (amt_i),
    .op_i    (op_i),
    .res_o   (res_d),
    .carry_o (carry_d)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      res_q   <= '0;
      carry_q <= 1'b0;
    end else begin
      res_q   <= res_d;
      carry_q <= carry_d;
    end
  end

  assign result_o = res_q;
  assign carry_o  = carry_q;
endmodule

// File: rtl/rotc_shifter_chk.sv
module rotc_shifter_chk
  import rotc_shifter_pkg::*;
#(
  parameter int W  = 32,
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rst_sync_n,
  input logic [W-1:0]  data_i,
  input logic [AW-1:0] amt_i,
  input logic [2:0]    op_i,
  input logic          carry_i,
  input logic [W-1:0]  result_o,
  input logic          carry_o
);
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_sync_n |-> (result_o == '0 && !carry_o));

  a_r3_zero_amount: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_sync_n && amt_i == '0) |=>
      (result_o == $past(data_i) && carry_o == $past(carry_i)));

  a_r7_undefined_op: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_sync_n && op_i[2:1] == 2'b11) |=>
      (result_o == $past(data_i) && carry_o == $past(carry_i)));

  a_r4_shl_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_sync_n && op_i == OP_SHL) |=>
      ((result_o & ~({W{1'b1}} << $past(amt_i))) == '0));

  a_r4_shr_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_sync_n && op_i == OP_SHR) |=>
      ((result_o & ~({W{1'b1}} >> $past(amt_i))) == '0));

  a_r5_rotate_keeps_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_sync_n && (op_i == OP_ROL || op_i == OP_ROR)) |=>
      ($countones(result_o) == $countones($past(data_i))));

  a_r5_rol_carry_lsb: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_sync_n && op_i == OP_ROL && amt_i != '0) |=> (carry_o == result_o[0]));

  a_r5_ror_carry_msb: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_sync_n && op_i == OP_ROR && amt_i != '0) |=> (carry_o == result_o[W-1]));

  a_r6_carry_ring_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_sync_n && (op_i == OP_ROLC || op_i == OP_RORC)) |=>
      ($countones({carry_o, result_o}) == $countones($past({carry_i, data_i}))));
endmodule

bind rotc_shifter rotc_shifter_chk #(.W(W), .AW(AW)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .rst_sync_n (rst_sync_n),
  .data_i     (data_i),
  .amt_i      (amt_i),
  .op_i       (op_i),
  .carry_i    (carry_i),
  .result_o   (result_o),
  .carry_o    (carry_o)
);

// File: tb/rotc_shifter_tb_top.sv
module rotc_shifter_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic [31:0] data_i;
  logic [4:0]  amt_i;
  logic [2:0]  op_i;
  logic        carry_i;
  logic [31:0] result_o;
  logic        carry_o;

  int checks = 0;
  int fails  = 0;

  rotc_shifter dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .data_i   (data_i),
    .amt_i    (amt_i),
    .op_i     (op_i),
    .carry_i  (carry_i),
    .result_o (result_o),
    .carry_o  (carry_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Bit-stepping model: returns {carry, word}
  function automatic logic [32:0] model(logic [31:0] d, logic [4:0] a,
                                        logic [2:0] o, logic c);
    logic [31:0] r;
    logic [32:0] v;
    logic        co;
    r  = d;
    v  = {c, d};
    co = c;
    if (a == 0 || o > 3'd5) return {c, d};
    for (int i = 0; i < int'(a); i++) begin
      case (o)
        3'd0: begin co = r[31]; r = {r[30:0], 1'b0}; end
        3'd1: begin co = r[0];  r = {1'b0, r[31:1]}; end
        3'd2: r = {r[30:0], r[31]};
        3'd3: r = {r[0], r[31:1]};
        3'd4: v = {v[31:0], v[32]};
        default: v = {v[0], v[32:1]};
      endcase
    end
    if (o == 3'd2) co = r[0];
    if (o == 3'd3) co = r[31];
    if (o >= 3'd4) return v;
    return {co, r};
  endfunction

  function automatic string tag_of(logic [4:0] a, logic [2:0] o);
    if (o > 3'd5)  return "R2 R7";
    if (a == 0)    return "R2 R3";
    if (o <= 3'd1) return "R2 R4";
    if (o <= 3'd3) return "R2 R5";
    return "R2 R6";
  endfunction

  // Called at a falling edge: drive, wait one rising edge, check at next falling edge
  task automatic run_one(logic [31:0] d, logic [4:0] a, logic [2:0] o, logic c);
    logic [32:0] exp_v;
    data_i  = d;
    amt_i   = a;
    op_i    = o;
    carry_i = c;
    exp_v   = model(d, a, o, c);
    @(negedge clk);
    checks++;
    if ({carry_o, result_o} !== exp_v) begin
      fails++;
      $display("FAIL %s op=%0d amt=%0d din=%h cin=%0b: actual c=%0b r=%h expected c=%0b r=%h",
               tag_of(a, o), o, a, d, c, carry_o, result_o, exp_v[32], exp_v[31:0]);
    end
  endtask

  task automatic check_zero(string what);
    checks++;
    if (result_o !== 32'h0 || carry_o !== 1'b0) begin
      fails++;
      $display("FAIL R1 %s: actual c=%0b r=%h expected c=0 r=00000000",
               what, carry_o, result_o);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd7741));
    rst_n   = 1'b0;
    data_i  = 32'hFFFF_FFFF;
    amt_i   = 5'd3;
    op_i    = 3'd2;
    carry_i = 1'b1;
    repeat (3) @(negedge clk);
    check_zero("during reset");            // R1
    rst_n = 1'b1;
    @(negedge clk);
    check_zero("one edge after release"); // R1
    @(negedge clk);
    check_zero("two edges after release"); // R1: register still held
    @(negedge clk);

    // R3: zero amount, every operation, both carries
    for (int o = 0; o < 6; o++) begin
      run_one(32'hA5C3_0F96, 5'd0, 3'(o), 1'b0);
      run_one(32'h0000_0001, 5'd0, 3'(o), 1'b1);
    end

    // R4/R5/R6: amounts 1 and 31 with single bits at either end
    for (int o = 0; o < 6; o++) begin
      run_one(32'h8000_0000, 5'd1,  3'(o), 1'b0);
      run_one(32'h0000_0001, 5'd1,  3'(o), 1'b1);
      run_one(32'h8000_0000, 5'd31, 3'(o), 1'b1);
      run_one(32'h0000_0001, 5'd31, 3'(o), 1'b0);
      run_one(32'hDEAD_BEEF, 5'd13, 3'(o), 1'b1);
    end

    // R7: undefined codes with nonzero amounts
    run_one(32'h1234_5678, 5'd7,  3'd6, 1'b1);
    run_one(32'h1234_5678, 5'd31, 3'd7, 1'b0);
    run_one(32'hFFFF_0000, 5'd16, 3'd7, 1'b1);

    // Random stream, inputs change every cycle (R2)
    for (int n = 0; n < 4000; n++) begin
      run_one($urandom, 5'($urandom_range(0, 31)), 3'($urandom_range(0, 7)),
              1'($urandom_range(0, 1)));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule